// File: doc/BRIEF.md
# Ratiometric Impedance Magnitude Calculator

This block turns two streams of 12-bit unsigned ADC codes into a single impedance magnitude. One stream carries the voltage across the unknown load. The other carries a reference voltage that is proportional to the excitation current. For each stream, the block finds the highest and lowest code seen during a fixed window of accepted samples. The difference between them is that window's peak-to-peak amplitude. The amplitudes of a power-of-two number of windows are summed, and the sum is shifted right to give an average.

The averaged load amplitude is given 7 fractional bits. It is then divided by the averaged reference amplitude in a restoring divider that produces one quotient bit per clock. The quotient is multiplied by the series-resistor constant (10000 by default). The result is an impedance magnitude in units of 1/128 ohm.

A start pulse clears all state and begins a measurement. The result appears together with a one-cycle done strobe and is held until the next start. A zero reference amplitude saturates the result and raises an error flag instead of dividing.

Top module: `imp_mag_calc`

## Requirements
- R1: After reset, `done`, `div_err` and `imp_mag` are all zero.
- R2: For each channel, the amplitude of a window is the largest accepted code minus the smallest accepted code among that window's WIN_LEN accepted samples. The extremes restart with every new window.
- R3: The averaged amplitude of a channel is floor(sum of the 2^AVG_LOG2 window amplitudes / 2^AVG_LOG2).
- R4: With a nonzero reference average, `imp_mag` = floor(load_avg * 128 / ref_avg) * RSER. Nothing is lost, even at the largest ratio, 4095*128.
- R5: `done` is high for exactly one cycle, 21 clock edges after the edge that accepts the last sample of the last window.
- R6: A zero reference average gives `imp_mag` all ones and `div_err` = 1. The `done` pulse comes one edge after the edge that accepts the last sample.
- R7: `start` clears `imp_mag`, `div_err` and any partial measurement on the next edge. A sample presented in the same cycle as `start` is not counted.
- R8: Samples presented while no measurement is acquiring are ignored. This covers the time the divide and multiply run and the time after `done`. Such samples change neither the result, nor the timing of `done`.
- R9: `imp_mag` and `div_err` keep their values until the next `start`.
- R10: A cycle with `smp_valid` low is not counted as a sample. Its codes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears state and begins a measurement |
| smp_valid | input | 1 | Qualifies both sample codes this cycle |
| smp_load | input | SAMPLE_W | Code of the voltage across the unknown load |
| smp_ref | input | SAMPLE_W | Code of the reference (current-proportional) voltage |
| imp_mag | output | SAMPLE_W+FRAC_BITS+clog2(RSER+1) | Impedance magnitude, 1/128 ohm per LSB |
| done | output | 1 | One-cycle strobe marking a fresh result |
| div_err | output | 1 | Reference amplitude was zero; result saturated |

## Verification
The assertions take for granted that reset is held low across at least one clock edge, so the result register has a known value before its stability is judged. They also assume that `start` is the only way a new measurement begins. The stimulus keeps to this: every run opens with a single-cycle `start`. The bench drives valid samples, on purpose, in the start cycle, while the divider runs and after completion, so the ignore rules are tested rather than avoided. It also sends a second `start` part-way through a run, so the only way the result changes outside a done cycle is through `start`.

// File: rtl/imp_pkg.sv
// Shared types for the impedance magnitude calculator.
package imp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for start
        ST_ACQ,     // collecting windows
        ST_PREP,    // averages ready, check divisor
        ST_DIV,     // serial division in progress
        ST_MUL      // scale quotient by resistor constant
    } calc_state_t;
endpackage

// File: rtl/extremum_tracker.sv
// Tracks the running max and min of one channel over a window.
// Assumes: clr has priority over upd. amp reflects the current sample, so
// the window-closing sample is included in the amplitude taken at clr.
module extremum_tracker #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] code,
    output logic [W-1:0] amp
);
    logic [W-1:0] hi_q, lo_q, hi_nxt, lo_nxt;

    // Candidate extremes including the present sample.
    always_comb begin
        hi_nxt = (upd && code > hi_q) ? code : hi_q;
        lo_nxt = (upd && code < lo_q) ? code : lo_q;
        amp    = hi_nxt - lo_nxt;
    end

    // Restart extremes at window boundaries, otherwise absorb samples.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q <= '0;
            lo_q <= '1;
        end else if (upd) begin
            hi_q <= hi_nxt;
            lo_q <= lo_nxt;
        end
    end
endmodule

// File: rtl/amp_averager.sv
// Sums window amplitudes and exposes the sum divided by 2^LOG2.
// Assumes exactly 2^LOG2 adds between clears, so the sum cannot overflow.
module amp_averager #(
    parameter int W    = 12,
    parameter int LOG2 = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] amp,
    output logic [W-1:0] avg
);
    localparam int ACC_W = W + LOG2;
    logic [ACC_W-1:0] acc_q;

    // Accumulate one amplitude per closed window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (add)      acc_q <= acc_q + ACC_W'(amp);
    end

    assign avg = acc_q[ACC_W-1:LOG2];
endmodule

// File: rtl/restoring_divider.sv
// Unsigned restoring divider, one quotient bit per clock, W steps.
// Assumes divisor is nonzero when load is asserted; last marks the final step.
module restoring_divider #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         last
);
    localparam int CNT_W = $clog2(W + 1);
    logic [W-1:0]     q_q, rem_q, dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       shifted;
    logic [W+1:0]     diff;
    logic             ge;

    // One trial subtraction of the shifted partial remainder.
    always_comb begin
        shifted = {rem_q, q_q[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs_q};
        ge      = !diff[W+1];
    end

    // Load operands, then shift-subtract until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0; rem_q <= '0; dvs_q <= '0; cnt_q <= '0;
        end else if (load) begin
            q_q   <= dividend;
            rem_q <= '0;
            dvs_q <= divisor;
            cnt_q <= CNT_W'(W);
        end else if (cnt_q != '0) begin
            q_q   <= {q_q[W-2:0], ge};
            rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quotient = q_q;
    assign last     = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/imp_mag_calc.sv
// Top of the ratiometric impedance magnitude calculator.
// Assumes WIN_LEN >= 2 and AVG_LOG2 >= 1. A start pulse aborts any activity;
// samples are accepted only while acquiring.
module imp_mag_calc
    import imp_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int WIN_LEN   = 1024,
    parameter int AVG_LOG2  = 3,
    parameter int FRAC_BITS = 7,
    parameter int RSER      = 10000
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             start,
    input  logic                                             smp_valid,
    input  logic [SAMPLE_W-1:0]                              smp_load,
    input  logic [SAMPLE_W-1:0]                              smp_ref,
    output logic [SAMPLE_W+FRAC_BITS+$clog2(RSER+1)-1:0]     imp_mag,
    output logic                                             done,
    output logic                                             div_err
);
    localparam int DIV_W  = SAMPLE_W + FRAC_BITS;
    localparam int OUT_W  = DIV_W + $clog2(RSER + 1);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int NCH    = 2;   // channel 0: load, channel 1: reference

    calc_state_t st_q;
    logic [WIN_W-1:0]    win_cnt_q;
    logic [AVG_LOG2-1:0] win_num_q;
    logic                accept, win_end, div_load, div_last;
    logic [NCH-1:0][SAMPLE_W-1:0] codes, amps, avgs;
    logic [DIV_W-1:0]    quo;

    assign codes    = {smp_ref, smp_load};
    assign accept   = (st_q == ST_ACQ) && smp_valid && !start;
    assign win_end  = accept && (win_cnt_q == WIN_W'(WIN_LEN - 1));
    assign div_load = (st_q == ST_PREP) && !start && (avgs[1] != '0);

    // Per-channel amplitude extraction and averaging.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        extremum_tracker #(.W(SAMPLE_W)) u_ext (
            .clk(clk), .rst_n(rst_n), .clr(start || win_end),
            .upd(accept), .code(codes[ch]), .amp(amps[ch])
        );
        amp_averager #(.W(SAMPLE_W), .LOG2(AVG_LOG2)) u_avg (
            .clk(clk), .rst_n(rst_n), .clr(start), .add(win_end),
            .amp(amps[ch]), .avg(avgs[ch])
        );
    end

    restoring_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load),
        .dividend({avgs[0], {FRAC_BITS{1'b0}}}),
        .divisor(DIV_W'(avgs[1])),
        .quotient(quo), .last(div_last)
    );

    // Sequencing, window counting and result registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; win_cnt_q <= '0; win_num_q <= '0;
            imp_mag <= '0; div_err <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                st_q <= ST_ACQ; win_cnt_q <= '0; win_num_q <= '0;
                imp_mag <= '0; div_err <= 1'b0;
            end else begin
                case (st_q)
                    ST_ACQ: if (accept) begin
                        if (win_end) begin
                            win_cnt_q <= '0;
                            win_num_q <= win_num_q + 1'b1;
                            if (win_num_q == '1) st_q <= ST_PREP;
                        end else begin
                            win_cnt_q <= win_cnt_q + 1'b1;
                        end
                    end
                    ST_PREP: if (avgs[1] == '0) begin
                        imp_mag <= '1; div_err <= 1'b1; done <= 1'b1;
                        st_q <= ST_IDLE;
                    end else begin
                        st_q <= ST_DIV;
                    end
                    ST_DIV: if (div_last) st_q <= ST_MUL;
                    ST_MUL: begin
                        imp_mag <= OUT_W'(quo) * OUT_W'(RSER);
                        done    <= 1'b1;
                        st_q    <= ST_IDLE;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/imp_mag_calc_chk.sv
// Protocol checks on the calculator's outputs, bound to the top module.
module imp_mag_calc_chk #(
    parameter int SAMPLE_W  = 12,
    parameter int FRAC_BITS = 7,
    parameter int RSER      = 10000
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         start,
    input logic                                         done,
    input logic                                         div_err,
    input logic [SAMPLE_W+FRAC_BITS+$clog2(RSER+1)-1:0] imp_mag
);
    // R5: the completion strobe lasts a single cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an error always comes with a saturated result.
    a_r6_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (&imp_mag));

    // R6: the error flag rises only together with the strobe.
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_err) |-> done);

    // R7: start wipes the result and error on the next edge.
    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !div_err && imp_mag == '0));

    // R9: the result changes only with the strobe or after a start.
    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || $stable(imp_mag)));
endmodule

bind imp_mag_calc imp_mag_calc_chk #(
    .SAMPLE_W(SAMPLE_W), .FRAC_BITS(FRAC_BITS), .RSER(RSER)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .div_err(div_err), .imp_mag(imp_mag)
);

// File: tb/imp_mag_calc_test.sv
// Self-checking bench with a behavioural reference model checked every clock.
module imp_mag_calc_test;
    localparam int SW = 12, WL = 16, AL = 2, FB = 7, RS = 10000;
    localparam int OW = SW + FB + $clog2(RS + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smp_valid = 1'b0;
    logic [SW-1:0] smp_load = '0, smp_ref = '0;
    logic [OW-1:0] imp_mag;
    logic done, div_err;

    int total = 0, bad = 0, cyc = 0;
    bit chk_on = 1'b0;
    string tag = "R1 reset";
    logic [OW-1:0] exp_res = '0, pend_res = '0;
    logic exp_err = 1'b0, pend_err = 1'b0;
    int pend_cyc = -1, exp_done_cyc = -1;

    imp_mag_calc #(.SAMPLE_W(SW), .WIN_LEN(WL), .AVG_LOG2(AL),
                   .FRAC_BITS(FB), .RSER(RS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
        .smp_load(smp_load), .smp_ref(smp_ref),
        .imp_mag(imp_mag), .done(done), .div_err(div_err));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Per-clock comparison against the model (R5 timing, R9 holding).
    always @(negedge clk) if (chk_on) begin
        if (cyc == pend_cyc) begin exp_res = pend_res; exp_err = pend_err; end
        total++;
        if (done !== (cyc == exp_done_cyc) || imp_mag !== exp_res || div_err !== exp_err) begin
            bad++;
            $display("FAIL %s (R5/R9 clock %0d) done=%0b exp=%0b result=%0d exp=%0d err=%0b exp=%0b",
                     tag, cyc, done, (cyc == exp_done_cyc), imp_mag, exp_res, div_err, exp_err);
        end
    end

    function automatic int tri_wave(int s);
        return (s % 16) < 8 ? (s % 16) : 15 - (s % 16);
    endfunction

    // Stimulus patterns per mode, channel 0 = load, 1 = reference.
    function automatic int gen(int mode, int ch, int w, int s);
        case (mode)
            0: return ch == 0 ? 1000 + tri_wave(s) * (150 + 20 * w) : 1500 + tri_wave(s) * (60 + 5 * w);
            1: return ch == 0 ? 900 + tri_wave(s) * 200 : 2000;
            2: return ch == 0 ? ((s % 2) ? 4095 : 0) : 2000 + ((s == 5) ? 1 : 0);
            3: return ch == 0 ? 3000 : 400 + tri_wave(s) * 70;
            4: return ch == 0 ? 5 + tri_wave(s) * 30 : 100 + ((s == 3) ? ((w == 0) ? 1 : 2) : 0);
            default: return ((s * 73 + w * 151 + ch * 211 + mode * 29) * 97) % 4096;
        endcase
    endfunction

    // R7: start with a coincident extreme sample that must not count.
    task automatic do_start();
        @(posedge clk); #2;
        start = 1'b1; smp_valid = 1'b1; smp_load = '1; smp_ref = '0;
        pend_cyc = cyc + 1; pend_res = '0; pend_err = 1'b0;
        @(posedge clk); #2;
        start = 1'b0; smp_valid = 1'b0;
    endtask

    // Drive a full measurement and predict result, error and strobe cycle.
    task automatic run_meas(int mode, bit gap, string t);
        int sum [2];
        int ld_avg, rf_avg, last_c;
        longint q;
        tag = t;
        sum[0] = 0; sum[1] = 0; last_c = 0;
        for (int w = 0; w < (1 << AL); w++) begin
            int mx [2];
            int mn [2];
            for (int c = 0; c < 2; c++) begin mx[c] = 0; mn[c] = 4095; end
            for (int s = 0; s < WL; s++) begin
                @(posedge clk); #2;
                smp_valid = 1'b1;
                smp_load = SW'(gen(mode, 0, w, s));
                smp_ref  = SW'(gen(mode, 1, w, s));
                last_c = cyc;
                for (int c = 0; c < 2; c++) begin
                    int v = gen(mode, c, w, s);
                    if (v > mx[c]) mx[c] = v;
                    if (v < mn[c]) mn[c] = v;
                end
                if (gap) begin   // R10: unqualified cycle with wild codes
                    @(posedge clk); #2;
                    smp_valid = 1'b0; smp_load = '1; smp_ref = SW'(s * 251);
                end
            end
            for (int c = 0; c < 2; c++) sum[c] += mx[c] - mn[c];   // R2
        end
        ld_avg = sum[0] >> AL;   // R3
        rf_avg = sum[1] >> AL;
        if (rf_avg == 0) begin   // R6
            exp_done_cyc = last_c + 2;
            pend_res = '1; pend_err = 1'b1;
        end else begin           // R4, R5
            q = longint'(ld_avg) * 128 / rf_avg;
            exp_done_cyc = last_c + 22;
            pend_res = OW'(q * RS); pend_err = 1'b0;
        end
        pend_cyc = exp_done_cyc;
        // R8: valid extreme samples while computing and after completion.
        for (int k = 0; k < 30; k++) begin
            @(posedge clk); #2;
            smp_valid = 1'b1; smp_load = SW'(k * 137); smp_ref = SW'(4095 - k * 61);
        end
        @(posedge clk); #2; smp_valid = 1'b0;
        @(negedge clk);
        total++;
        if (imp_mag !== pend_res || div_err !== pend_err) begin
            bad++;
            $display("FAIL %s final result=%0d exp=%0d err=%0b exp=%0b",
                     t, imp_mag, pend_res, div_err, pend_err);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (cyc < 150000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        total++;   // R1
        if (done !== 1'b0 || div_err !== 1'b0 || imp_mag !== '0) begin
            bad++;
            $display("FAIL R1 reset done=%0b err=%0b result=%0d exp=0/0/0", done, div_err, imp_mag);
        end
        chk_on = 1'b1;

        do_start(); run_meas(0, 1'b0, "R2/R3/R4/R7 triangle");
        do_start(); run_meas(0, 1'b1, "R10 gaps");
        do_start(); run_meas(1, 1'b0, "R6 zero reference");
        do_start(); run_meas(2, 1'b0, "R4 largest ratio");
        do_start(); run_meas(3, 1'b0, "R4 zero load");
        do_start(); run_meas(4, 1'b0, "R3 floor average");
        // R7: abort a partial measurement with a second start.
        do_start(); tag = "R7 abort";
        for (int s = 0; s < 30; s++) begin
            @(posedge clk); #2;
            smp_valid = 1'b1; smp_load = SW'(gen(7, 0, 0, s)); smp_ref = SW'(gen(7, 1, 0, s));
        end
        do_start(); run_meas(5, 1'b0, "R7 after abort");
        do_start(); run_meas(6, 1'b1, "R2 scattered codes");
        // R9: hold across idle cycles with stray samples.
        tag = "R8/R9 idle hold";
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #2;
            smp_valid = k[0]; smp_load = SW'(k * 300); smp_ref = SW'(k * 9);
        end
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule